// File: doc/BRIEF.md
# Bidirectional Strobed Handshake Port

This block is one byte-wide port that carries data in both directions between a processor and a peripheral. Each direction has its own handshake, and the two directions share one peripheral data bus.

For outbound traffic, the processor writes a byte. The block latches that byte and signals "output buffer full" to the peripheral. The peripheral pulls its acknowledge line low to take the byte. While acknowledge is low, the block drives the latched byte onto the shared bus. At all other times it leaves the bus undriven, so the peripheral can drive the bus itself.

For inbound traffic, the peripheral pulls its strobe low. The block captures the bus value on that falling edge and raises "input buffer full". A processor read of the port clears that flag.

A single interrupt request merges the two directions. Two enable flip-flops mask it, one per direction. The processor sets and clears each enable through a single-bit set/reset command that addresses bits of the companion control port. A mode-load pulse clears both enables and both buffer states.

All handshake inputs are sampled on the block clock. Edges are detected against the value seen on the previous cycle.

Top module: `strobed_bidir_port`

## Requirements
- R1: After reset, obfN is 1, ibf is 0, intr is 0 and perOe is 0.
- R2: A cycle with wrEn high latches wrData and drives obfN low from the next cycle on.
- R3: perOe equals the inverse of ackN, and perDout then shows the latest written byte. A falling edge on ackN returns obfN to 1 on the following cycle, unless a write arrives in the same cycle.
- R4: A falling edge on stbN captures perDin into the input latch, and ibf is 1 from the next cycle on. Later changes on perDin, with no new falling edge, do not alter rdData.
- R5: A cycle with rdEn high and no new strobe edge clears ibf on the next cycle. rdData shows the input latch at all times.
- R6: The output interrupt term is active when three things hold: the buffer is not full (obfN=1), the output enable is set, and ackN is high. A write removes this term from the next cycle on.
- R7: The input interrupt term is active when three things hold: ibf=1, the input enable is set, and stbN is high. A read removes this term from the next cycle on. intr is the OR of the two terms, registered one cycle after its inputs.
- R8: The output enable is set or cleared by a bit set/reset command to port-C bit index 6 (bsrSel=6, bsrSet gives the value). The input enable is set or cleared by the same command at bit index 4. With both enables clear, intr stays 0.
- R9: A bit set/reset command to any other bit index leaves both enables unchanged.
- R10: A modeLoad pulse clears both enables, sets obfN to 1 and ibf to 0, and forces intr to 0 on the next cycle.
- R11: Inbound and outbound transfers may interleave in any order, provided each write precedes its acknowledge and each strobe precedes its read.
- R12: A second write before acknowledge overwrites the latched byte, and obfN stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeLoad | input | 1 | Mode-change pulse that clears enables and buffer state |
| wrEn | input | 1 | Processor write strobe, one cycle |
| wrData | input | DATA_W | Processor write byte |
| rdEn | input | 1 | Processor read strobe, one cycle |
| rdData | output | DATA_W | Input latch contents |
| bsrEn | input | 1 | Bit set/reset command valid |
| bsrSel | input | SEL_W | Port-C bit index addressed by the command |
| bsrSet | input | 1 | Value written to the addressed bit |
| perDin | input | DATA_W | Peripheral bus value seen by the block |
| perDout | output | DATA_W | Value the block drives on the peripheral bus |
| perOe | output | 1 | Peripheral bus drive enable |
| stbN | input | 1 | Peripheral strobe, active low |
| ackN | input | 1 | Peripheral acknowledge, active low |
| obfN | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Merged interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, an 8-bit companion port, and the enables at bit indices 6 and 4. This exercises the real decode of the set/reset index, including the neighbouring indices 5 and 7, which must be ignored. With the default width, distinct byte patterns show whether outbound and inbound data stay separate on the shared bus. The directed scenarios cover several cases:
- interleaved transfers, where one interrupt term masks or reveals the other;
- an overwrite before acknowledge;
- a mode load that lands on full buffers.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadOut;   // capture processor byte
    logic loadIn;    // capture peripheral byte
    logic clearAll;  // mode change: clear latches
  } sbpStrobes_t;
endpackage

// File: rtl/sbp_ctrl.sv
module sbp_ctrl
  import sbp_pkg::*;
#(
  parameter int PORTC_W   = 8,
  parameter int INTE1_BIT = 6,
  parameter int INTE2_BIT = 4,
  localparam int SEL_W    = $clog2(PORTC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeLoad,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             bsrEn,
  input  logic [SEL_W-1:0] bsrSel,
  input  logic             bsrSet,
  input  logic             stbN,
  input  logic             ackN,
  output sbpStrobes_t      strobes,
  output logic             obfN,
  output logic             ibf,
  output logic             intr,
  output logic             inteOut,
  output logic             inteIn
);
  logic stbPrev, ackPrev;
  logic obfFull, obfNext;
  logic ibfQ, ibfNext;
  logic inte1Q, inte1Next, inte2Q, inte2Next;
  logic intrQ, intrNext;
  logic stbFall, ackFall;

  assign stbFall = stbPrev & ~stbN;
  assign ackFall = ackPrev & ~ackN;

  always_comb begin
    strobes.loadOut  = wrEn;
    strobes.loadIn   = stbFall;
    strobes.clearAll = modeLoad;
  end

  always_comb begin
    obfNext = obfFull;
    if (modeLoad)     obfNext = 1'b0;
    else if (wrEn)    obfNext = 1'b1;
    else if (ackFall) obfNext = 1'b0;
  end

  always_comb begin
    ibfNext = ibfQ;
    if (modeLoad)     ibfNext = 1'b0;
    else if (stbFall) ibfNext = 1'b1;
    else if (rdEn)    ibfNext = 1'b0;
  end

  always_comb begin
    inte1Next = inte1Q;
    inte2Next = inte2Q;
    if (modeLoad) begin
      inte1Next = 1'b0;
      inte2Next = 1'b0;
    end else if (bsrEn) begin
      if (bsrSel == SEL_W'(INTE1_BIT)) inte1Next = bsrSet;
      if (bsrSel == SEL_W'(INTE2_BIT)) inte2Next = bsrSet;
    end
  end

  always_comb begin
    intrNext = (ibfNext & inte2Next & stbN) | (~obfNext & inte1Next & ackN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbPrev <= 1'b1;
      ackPrev <= 1'b1;
      obfFull <= 1'b0;
      ibfQ    <= 1'b0;
      inte1Q  <= 1'b0;
      inte2Q  <= 1'b0;
      intrQ   <= 1'b0;
    end else begin
      stbPrev <= stbN;
      ackPrev <= ackN;
      obfFull <= obfNext;
      ibfQ    <= ibfNext;
      inte1Q  <= inte1Next;
      inte2Q  <= inte2Next;
      intrQ   <= intrNext;
    end
  end

  assign obfN    = ~obfFull;
  assign ibf     = ibfQ;
  assign intr    = intrQ;
  assign inteOut = inte1Q;
  assign inteIn  = inte2Q;
endmodule

// File: rtl/sbp_datapath.sv
module sbp_datapath
  import sbp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbpStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] perDin,
  input  logic              ackN,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] perDout,
  output logic              perOe
);
  logic [DATA_W-1:0] outLatch, inLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      inLatch  <= '0;
    end else if (strobes.clearAll) begin
      outLatch <= '0;
      inLatch  <= '0;
    end else begin
      if (strobes.loadOut) outLatch <= wrData;
      if (strobes.loadIn)  inLatch  <= perDin;
    end
  end

  assign rdData  = inLatch;
  assign perDout = outLatch;
  assign perOe   = ~ackN;
endmodule

// File: rtl/strobed_bidir_port.sv
module strobed_bidir_port
  import sbp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int PORTC_W   = 8,
  parameter int INTE1_BIT = 6,
  parameter int INTE2_BIT = 4,
  localparam int SEL_W    = $clog2(PORTC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              bsrEn,
  input  logic [SEL_W-1:0]  bsrSel,
  input  logic              bsrSet,
  input  logic [DATA_W-1:0] perDin,
  output logic [DATA_W-1:0] perDout,
  output logic              perOe,
  input  logic              stbN,
  input  logic              ackN,
  output logic              obfN,
  output logic              ibf,
  output logic              intr
);
  sbpStrobes_t strobes;
  logic inteOut, inteIn;

  sbp_ctrl #(
    .PORTC_W(PORTC_W), .INTE1_BIT(INTE1_BIT), .INTE2_BIT(INTE2_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .wrEn(wrEn), .rdEn(rdEn),
    .bsrEn(bsrEn), .bsrSel(bsrSel), .bsrSet(bsrSet), .stbN(stbN), .ackN(ackN),
    .strobes(strobes), .obfN(obfN), .ibf(ibf), .intr(intr),
    .inteOut(inteOut), .inteIn(inteIn)
  );

  sbp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .perDin(perDin),
    .ackN(ackN), .rdData(rdData), .perDout(perDout), .perOe(perOe)
  );
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker (
  input logic clk,
  input logic rstN,
  input logic modeLoad,
  input logic wrEn,
  input logic rdEn,
  input logic stbN,
  input logic ackN,
  input logic obfN,
  input logic ibf,
  input logic intr,
  input logic inteOut,
  input logic inteIn
);
  // R2
  wr_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !modeLoad) |=> !obfN);
  // R3
  ack_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && !wrEn && !modeLoad) |=> obfN);
  // R4
  stb_fills_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(stbN) && !modeLoad) |=> ibf);
  // R5
  rd_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && stbN) |=> !ibf);
  // R8
  intr_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inteOut && !inteIn) |-> !intr);
  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeLoad |=> (obfN && !ibf && !intr && !inteOut && !inteIn));
endmodule

bind strobed_bidir_port sbp_checker u_chk (
  .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .wrEn(wrEn), .rdEn(rdEn),
  .stbN(stbN), .ackN(ackN), .obfN(obfN), .ibf(ibf), .intr(intr),
  .inteOut(inteOut), .inteIn(inteIn)
);

// File: tb/strobed_bidir_port_tb.sv
`timescale 1ns/1ps
module strobed_bidir_port_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeLoad = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic bsrEn = 1'b0, bsrSet = 1'b0;
  logic [2:0] bsrSel = '0;
  logic [7:0] wrData = '0, perDin = '0;
  logic stbN = 1'b1, ackN = 1'b1;
  logic [7:0] rdData, perDout;
  logic perOe, obfN, ibf, intr;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  strobed_bidir_port u_dut (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .bsrEn(bsrEn), .bsrSel(bsrSel), .bsrSet(bsrSet),
    .perDin(perDin), .perDout(perDout), .perOe(perOe), .stbN(stbN), .ackN(ackN),
    .obfN(obfN), .ibf(ibf), .intr(intr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bsr(input int sel, input logic val);
    bsrEn = 1'b1; bsrSel = 3'(sel); bsrSet = val;
    tick();
    bsrEn = 1'b0;
  endtask

  task automatic cpuWrite(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic cpuRead();
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic strobeIn(input logic [7:0] d);
    perDin = d; stbN = 1'b0;
    tick();
    stbN = 1'b1;
    tick();
  endtask

  task automatic testReset();
    chk("R1 obfN", obfN, 1); chk("R1 ibf", ibf, 0);
    chk("R1 intr", intr, 0); chk("R1 perOe", perOe, 0);
  endtask

  task automatic testOutput();
    bsr(6, 1'b1);
    chk("R6 intr empty+enabled", intr, 1);
    chk("R8 set via bit 6", intr, 1);
    cpuWrite(8'hA5);
    chk("R2 obfN low", obfN, 0);
    chk("R6 intr after write", intr, 0);
    chk("R3 bus idle ack high", perOe, 0);
    ackN = 1'b0; #1;
    chk("R3 oe during ack", perOe, 1);
    chk("R3 data during ack", perDout, 8'hA5);
    @(negedge clk);
    chk("R3 obfN released", obfN, 1);
    chk("R6 intr held while ack low", intr, 0);
    ackN = 1'b1;
    tick();
    chk("R6 intr after ack release", intr, 1);
    bsr(6, 1'b0);
    chk("R8 output term masked", intr, 0);
  endtask

  task automatic testInput();
    bsr(4, 1'b1);
    perDin = 8'h3C; stbN = 1'b0;
    tick();
    chk("R4 ibf set", ibf, 1);
    chk("R7 intr low during strobe", intr, 0);
    stbN = 1'b1; perDin = 8'hFF;
    tick();
    chk("R7 intr after strobe release", intr, 1);
    chk("R4 latch held", rdData, 8'h3C);
    cpuRead();
    chk("R5 ibf cleared", ibf, 0);
    chk("R7 intr after read", intr, 0);
    bsr(4, 1'b0);
    strobeIn(8'h5A);
    chk("R8 input term masked", intr, 0);
    cpuRead();
  endtask

  task automatic testIgnore();
    bsr(5, 1'b1);
    bsr(7, 1'b1);
    bsr(3, 1'b1);
    chk("R9 other bits leave output enable clear", intr, 0);
    strobeIn(8'h77);
    chk("R9 other bits leave input enable clear", intr, 0);
    cpuRead();
  endtask

  task automatic testMode();
    bsr(6, 1'b1); bsr(4, 1'b1);
    cpuWrite(8'h12);
    strobeIn(8'h34);
    chk("R7 input term with full outbound", intr, 1);
    modeLoad = 1'b1;
    tick();
    modeLoad = 1'b0;
    chk("R10 obfN", obfN, 1); chk("R10 ibf", ibf, 0); chk("R10 intr", intr, 0);
    tick();
    chk("R10 enables cleared", intr, 0);
  endtask

  task automatic testInterleave();
    bsr(6, 1'b1); bsr(4, 1'b1);
    cpuWrite(8'h11);
    strobeIn(8'h22);
    chk("R11 ibf with pending out", ibf, 1);
    chk("R11 obf with pending in", obfN, 0);
    ackN = 1'b0; #1;
    chk("R11 out byte", perDout, 8'h11);
    @(negedge clk);
    ackN = 1'b1;
    tick();
    chk("R11 intr both", intr, 1);
    chk("R11 in byte", rdData, 8'h22);
    cpuRead();
    chk("R11 intr output term only", intr, 1);
    cpuWrite(8'h33);
    chk("R11 intr none", intr, 0);
    cpuWrite(8'h44);
    chk("R12 still full", obfN, 0);
    ackN = 1'b0; #1;
    chk("R12 overwritten byte", perDout, 8'h44);
    @(negedge clk);
    ackN = 1'b1;
    tick();
    bsr(6, 1'b0); bsr(4, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testOutput();
    testInput();
    testIgnore();
    testMode();
    testInterleave();
    finished = 1;
    summary();
  end
endmodule